// File: doc/BRIEF.md
# Serial Polynomial Signature Divider

This block compacts a serial bit stream into a short signature. It treats the stream as the coefficients of a polynomial, with the highest-degree coefficient arriving first. It divides that polynomial by a fixed divisor, P(x) = 1 + x^2 + x^4 + x^5. The divider is a 5-stage shift register with an XOR inside the register at each tapped stage. Each bit that is shifted out of the last stage is one quotient coefficient. After the last bit of the stream, the register holds the remainder, and that remainder is the signature.

The bit offered on a cycle is taken only when the enable is high. With the enable low, the register keeps its contents. A synchronous clear sets the register to zero, so the next stream can start. Each enabled step also produces a quotient bit together with a valid strobe. A test-response compactor can use the remainder, and the quotient stream can be used for debug or for checking a division.

Top module: `sig_divider`

## Requirements
- R1: When `srst` is high at a rising clock edge, `sig_q` reads 0 after that edge. This holds whatever `bit_en` and `bit_in` are.
- R2: When `bit_en` is low and `srst` is low at an edge, `sig_q` does not change, whatever `bit_in` is.
- R3: Bit i of `sig_q` is stage ri. On an enabled step with feedback f = r4 taken before the step, the new values are: r0 = bit_in XOR f, r1 = r0, r2 = r1 XOR f, r3 = r2, r4 = r3 XOR f.
- R4: Start from zero and feed the stream 1,1,1,1,0,1,0,1 for G(x) = x^7+x^6+x^5+x^4+x^2+1. After bits 1, 5, 6, 7 and 8, `sig_q` reads 0x01, 0x1E, 0x08, 0x10 and 0x14. The final value 0x14 is the remainder x^2+x^4.
- R5: `quo_vld` is high exactly when `bit_en` is high and `srst` is low. `quo_bit` equals r4 before the step while `quo_vld` is high, and is 0 otherwise. For the R4 stream the eight quotient bits are 0,0,0,0,0,1,0,1, which give the quotient 1+x^2.
- R6: Start from zero and feed a stream that is P(x) itself (bits 1,1,0,1,0,1). The remainder is then 0, and the final quotient bit is 1.
- R7: Pausing a stream, by holding `bit_en` low between bits, does not change the final signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous clear of the remainder register |
| bit_en | input | 1 | Take `bit_in` on this edge |
| bit_in | input | 1 | Serial stream bit, highest degree first |
| sig_q | output | DEG | Remainder register, bit i = stage ri |
| quo_bit | output | 1 | Quotient bit leaving the last stage on this step |
| quo_vld | output | 1 | Strobe marking a valid `quo_bit` |

## Verification
The bench builds the divider with its default parameters, DEG = 5 and TAPS = 5'b10101, so it exercises exactly the degree-5 divisor given above. With this setting the known division trace and the zero-remainder stream of P(x) can be checked value by value. A 64-bit pseudo-random stream, with pauses inserted, is also run against a bench model of the stage equations, which covers tapped and untapped stages under both feedback values.

// File: rtl/sig_divider.sv
module sig_divider #(
  parameter int             DEG  = 5,
  parameter logic [DEG-1:0] TAPS = 5'b10101
) (
  input  logic           clk,
  input  logic           srst,
  input  logic           bit_en,
  input  logic           bit_in,
  output logic [DEG-1:0] sig_q,
  output logic           quo_bit,
  output logic           quo_vld
);

  logic [DEG-1:0] rem_q;
  logic [DEG-1:0] rem_d;
  logic           fb;
  logic           step;

  assign fb    = rem_q[DEG-1];
  assign step  = bit_en & ~srst;
  assign rem_d = {rem_q[DEG-2:0], bit_in} ^ (TAPS & {DEG{fb}});

  always_ff @(posedge clk) begin
    if (srst)        rem_q <= '0;
    else if (bit_en) rem_q <= rem_d;
  end

  assign sig_q   = rem_q;
  assign quo_vld = step;
  assign quo_bit = step & fb;

endmodule

// File: rtl/sig_divider_chk.sv
module sig_divider_chk #(
  parameter int             DEG  = 5,
  parameter logic [DEG-1:0] TAPS = 5'b10101
) (
  input logic           clk,
  input logic           srst,
  input logic           bit_en,
  input logic           bit_in,
  input logic [DEG-1:0] sig_q,
  input logic           quo_bit,
  input logic           quo_vld
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  a_r1_clear: assert property (@(posedge clk) disable iff (srst)
    (armed && $past(srst)) |-> (sig_q == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (srst)
    (armed && !bit_en) |=> $stable(sig_q));

  a_r3_stage_shift: assert property (@(posedge clk) disable iff (srst)
    (armed && bit_en) |=>
      ((sig_q[DEG-1:1] ^ $past(sig_q[DEG-2:0])) ==
       ($past(quo_bit) ? TAPS[DEG-1:1] : '0)));

  a_r5_first_stage: assert property (@(posedge clk) disable iff (srst)
    (armed && bit_en) |=> (sig_q[0] == ($past(bit_in) ^ $past(quo_bit))));

  a_r5_strobe: assert property (@(posedge clk) disable iff (srst)
    quo_vld == bit_en);

  a_r5_quo_gated: assert property (@(posedge clk)
    quo_bit |-> quo_vld);

endmodule

bind sig_divider sig_divider_chk #(.DEG(DEG), .TAPS(TAPS)) chk_i (
  .clk(clk), .srst(srst), .bit_en(bit_en), .bit_in(bit_in),
  .sig_q(sig_q), .quo_bit(quo_bit), .quo_vld(quo_vld)
);

// File: tb/sig_divider_tb_top.sv
module sig_divider_tb_top;
  localparam int             DEG  = 5;
  localparam logic [DEG-1:0] TAPS = 5'b10101;
  localparam int             NV   = 20;

  // {srst, en, in, expected sig after edge[4:0], expected quo_bit}
  localparam logic [8:0] VEC [NV] = '{
    {3'b100, 5'h00, 1'b0},  // R1 clear
    {3'b011, 5'h01, 1'b0},  // R4 bit1
    {3'b011, 5'h03, 1'b0},
    {3'b001, 5'h03, 1'b0},  // R2/R7 pause, bit ignored
    {3'b011, 5'h07, 1'b0},
    {3'b011, 5'h0F, 1'b0},
    {3'b010, 5'h1E, 1'b0},  // R4 bit5
    {3'b011, 5'h08, 1'b1},  // R4 bit6
    {3'b000, 5'h08, 1'b0},  // R7 pause
    {3'b010, 5'h10, 1'b0},  // R4 bit7
    {3'b011, 5'h14, 1'b1},  // R4 bit8 remainder
    {3'b111, 5'h00, 1'b0},  // R1 clear wins over enable, R5 no quotient
    {3'b011, 5'h01, 1'b0},  // R6 stream of P
    {3'b011, 5'h03, 1'b0},
    {3'b010, 5'h06, 1'b0},
    {3'b011, 5'h0D, 1'b0},
    {3'b010, 5'h1A, 1'b0},
    {3'b011, 5'h00, 1'b1},  // R6 zero remainder
    {3'b001, 5'h00, 1'b0},  // R2 hold at zero
    {3'b000, 5'h00, 1'b0}
  };

  logic           clk = 1'b0;
  logic           srst = 1'b1;
  logic           bit_en = 1'b0;
  logic           bit_in = 1'b0;
  logic [DEG-1:0] sig_q;
  logic           quo_bit;
  logic           quo_vld;
  int             checks = 0;
  int             errors = 0;

  always #4 clk = ~clk;

  sig_divider #(.DEG(DEG), .TAPS(TAPS)) dut_i (
    .clk(clk), .srst(srst), .bit_en(bit_en), .bit_in(bit_in),
    .sig_q(sig_q), .quo_bit(quo_bit), .quo_vld(quo_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DEG-1:0] model(input logic [DEG-1:0] s, input logic b);
    logic f;
    f = s[4];
    return {s[3] ^ f, s[2], s[1] ^ f, s[0], b ^ f};
  endfunction

  task automatic drive(input logic r, input logic e, input logic b,
                       input logic [DEG-1:0] exp_sig, input logic exp_quo, input string req);
    @(negedge clk);
    srst = r; bit_en = e; bit_in = b;
    #1;
    chk({req, " quo_vld"}, quo_vld, e & ~r);
    chk({req, " quo_bit"}, quo_bit, exp_quo);
    @(posedge clk);
    #1;
    chk({req, " sig_q"}, sig_q, exp_sig);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DEG-1:0] m;
    logic [15:0]    lf;
    logic           q;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset state", sig_q, 5'h00);

    for (int i = 0; i < NV; i++)
      drive(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:1], VEC[i][0], $sformatf("R3 vec%0d", i));

    drive(1'b0, 1'b1, 1'b1, 5'h01, 1'b0, "R3 load");
    for (int k = 0; k < 5; k++)
      drive(1'b0, 1'b0, k[0], 5'h01, 1'b0, "R2 long pause");
    drive(1'b1, 1'b0, 1'b0, 5'h00, 1'b0, "R1 clear");

    m  = '0;
    lf = 16'hACE1;
    for (int k = 0; k < 64; k++) begin
      q = m[4];
      m = model(m, lf[0]);
      drive(1'b0, 1'b1, lf[0], m, q, "R3 random step");
      if (k % 7 == 3) drive(1'b0, 1'b0, ~lf[0], m, 1'b0, "R7 random pause");
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule